// File: doc/BRIEF.md
# SMBus Quick Command Slave Handler

This block sits next to an I2C slave shift engine and turns its decoded bus events into SMBus Quick Command status. A Quick Command is a transfer made of an address byte alone. The read/write position of that byte carries the one bit of command data, and STOP follows with no data byte. The engine reports single-cycle pulses: START or repeated START, an address match with its direction bit, each completed data bit, a request for the next transmit byte, the loading of the transmit byte, and STOP. The host writes transmit bytes through a write strobe and acknowledges the STOP interrupt with a pulse.

When a matched transfer closes with STOP and no completed data bit after the address acknowledge, the block classifies it as a Quick Command. It raises a quick-command flag and latches the direction bit into a captured-direction flag. For a read-direction address, the block raises a data-request interrupt and asks the engine to hold SCL low. The host then supplies a byte; 0xFF is the usual filler, because its bit 7 is the first bit the master samples. The byte reaches the engine unaltered. Both flags stay set until the next address match.

Top module: `qc_slave_handler`

## Requirements
- R1: After reset, every output (data_req_irq, stop_irq, qcmd_flag, qcmd_dir, scl_hold, tx_valid, tx_byte) is 0.
- R2: An address match with direction 0 leaves data_req_irq and scl_hold at 0. A STOP after it with no completed data bit sets qcmd_flag=1, qcmd_dir=0 and stop_irq=1 on the cycle after the STOP pulse.
- R3: An address match with direction 1 sets data_req_irq=1 and scl_hold=1 on the cycle after the match pulse.
- R4: A host write while data_req_irq=1 is accepted. On the next cycle tx_byte equals the written byte unaltered, tx_valid=1, and data_req_irq and scl_hold are 0. A read-direction transfer that then ends in STOP with no completed data bit sets qcmd_flag=1, qcmd_dir=1 and stop_irq=1.
- R5: A matched transfer that ends in STOP after one or more completed data bits sets stop_irq=1 and leaves qcmd_flag at 0.
- R6: qcmd_flag and qcmd_dir clear on the cycle after the next address match. A START that is not followed by an address match leaves them unchanged.
- R7: A repeated START in place of STOP ends the transfer. It sets neither qcmd_flag nor stop_irq, and it clears data_req_irq and tx_valid.
- R8: A host write while data_req_irq=0 is ignored: tx_byte and tx_valid keep their values.
- R9: A STOP that arrives when no address has matched since the last START leaves stop_irq at 0 and the flags unchanged.
- R10: A stop_ack pulse clears stop_irq on the next cycle and does not touch qcmd_flag or qcmd_dir.
- R11: In a read-direction transfer, a next-byte request from the engine raises data_req_irq again. A transmit-load pulse clears tx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | START or repeated START seen (pulse) |
| ev_stop | input | 1 | STOP seen (pulse) |
| ev_addr_match | input | 1 | Own address received and acknowledged (pulse) |
| ev_rw | input | 1 | Direction bit of the address byte, valid with ev_addr_match |
| ev_bit | input | 1 | One data bit completed after the address acknowledge (pulse) |
| ev_tx_next | input | 1 | Master acknowledged a sent byte and wants another (pulse) |
| ev_tx_load | input | 1 | Engine took tx_byte into its shifter (pulse) |
| host_wr | input | 1 | Host transmit-byte write strobe |
| host_wdata | input | DATA_W | Host transmit byte |
| stop_ack | input | 1 | Host clears the STOP interrupt (pulse) |
| data_req_irq | output | 1 | Data-request interrupt bit |
| stop_irq | output | 1 | STOP interrupt bit |
| qcmd_flag | output | 1 | Last matched transfer was a Quick Command |
| qcmd_dir | output | 1 | Direction bit captured from that Quick Command |
| scl_hold | output | 1 | Ask the engine to stretch SCL until the host supplies a byte |
| tx_byte | output | DATA_W | Byte handed to the engine |
| tx_valid | output | 1 | tx_byte holds an unsent host byte |

## Verification
On every cycle, the assertions check that a read-direction match raises the data request and a write-direction match does not. They also check that an unrequested host write cannot change the transmit byte, and that the quick-command flag can only rise on a STOP. They further check that a repeated START never raises it, and that the STOP interrupt and transmit-valid bits clear on their acknowledge and load pulses. Only the bench scenarios show the classification across whole transfers: a STOP with zero data bits versus one after a full byte, a STOP with no matched address, the flags persisting across an unmatched START, and a re-request in a multi-byte read.

// File: rtl/qc_pkg.sv
package qc_pkg;
  // Transfer phase as seen from this slave
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,  // not addressed since the last START/STOP
    PH_ADDR   = 2'd1,  // own address acknowledged, no data bit yet
    PH_DATA   = 2'd2   // at least one data bit completed
  } phase_t;
endpackage

// File: rtl/qc_phase_tracker.sv
module qc_phase_tracker
  import qc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_start,
  input  logic ev_stop,
  input  logic ev_addr_match,
  input  logic ev_rw,
  input  logic ev_bit,
  output logic active,
  output logic dir,
  output logic matched_pulse,
  output logic end_stop,
  output logic end_quick
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  phase_t           phase_q;
  logic             dir_q;
  logic [CNT_W-1:0] bits_q;

  assign active        = (phase_q != PH_IDLE);
  assign dir           = dir_q;
  assign matched_pulse = ev_addr_match && !ev_stop && !ev_start;
  assign end_stop      = ev_stop && active;
  assign end_quick     = end_stop && (bits_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      dir_q   <= 1'b0;
      bits_q  <= '0;
    end else if (ev_stop || ev_start) begin
      phase_q <= PH_IDLE;
      bits_q  <= '0;
    end else if (ev_addr_match) begin
      phase_q <= PH_ADDR;
      dir_q   <= ev_rw;
      bits_q  <= '0;
    end else if (ev_bit && active) begin
      phase_q <= PH_DATA;
      if (bits_q != CNT_MAX) bits_q <= bits_q + 1'b1;
    end
  end
endmodule

// File: rtl/qc_tx_buffer.sv
module qc_tx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  input  logic              flush,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte  <= '0;
      tx_valid <= 1'b0;
    end else begin
      if (accept) tx_byte <= wdata;
      if (flush)       tx_valid <= 1'b0;
      else if (accept) tx_valid <= 1'b1;
      else if (load)   tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/qc_status_regs.sv
module qc_status_regs (
  input  logic clk,
  input  logic rst,
  input  logic matched,
  input  logic match_rd,
  input  logic next_req,
  input  logic host_accept,
  input  logic flush,
  input  logic end_stop,
  input  logic end_quick,
  input  logic dir,
  input  logic stop_ack,
  output logic data_req_irq,
  output logic scl_hold,
  output logic stop_irq,
  output logic qcmd_flag,
  output logic qcmd_dir
);
  logic req_d;

  always_comb begin
    req_d = data_req_irq;
    if (flush)                     req_d = 1'b0;
    else if (match_rd || next_req) req_d = 1'b1;
    else if (host_accept)          req_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_req_irq <= 1'b0;
      scl_hold     <= 1'b0;
      stop_irq     <= 1'b0;
      qcmd_flag    <= 1'b0;
      qcmd_dir     <= 1'b0;
    end else begin
      data_req_irq <= req_d;
      scl_hold     <= req_d;
      if (end_stop)      stop_irq <= 1'b1;
      else if (stop_ack) stop_irq <= 1'b0;
      if (end_quick) begin
        qcmd_flag <= 1'b1;
        qcmd_dir  <= dir;
      end else if (matched) begin
        qcmd_flag <= 1'b0;
        qcmd_dir  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qc_slave_handler.sv
module qc_slave_handler #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_addr_match,
  input  logic              ev_rw,
  input  logic              ev_bit,
  input  logic              ev_tx_next,
  input  logic              ev_tx_load,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              stop_ack,
  output logic              data_req_irq,
  output logic              stop_irq,
  output logic              qcmd_flag,
  output logic              qcmd_dir,
  output logic              scl_hold,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_valid
);
  logic active, dir, matched, end_stop, end_quick;
  logic host_accept, flush, match_rd, next_req;

  assign flush       = ev_start || ev_stop;
  assign host_accept = host_wr && data_req_irq && !flush;
  assign match_rd    = matched && ev_rw;
  assign next_req    = ev_tx_next && active && dir && !ev_addr_match;

  qc_phase_tracker #(.DATA_W(DATA_W)) u_phase (
    .clk           (clk),
    .rst           (rst),
    .ev_start      (ev_start),
    .ev_stop       (ev_stop),
    .ev_addr_match (ev_addr_match),
    .ev_rw         (ev_rw),
    .ev_bit        (ev_bit),
    .active        (active),
    .dir           (dir),
    .matched_pulse (matched),
    .end_stop      (end_stop),
    .end_quick     (end_quick)
  );

  qc_tx_buffer #(.DATA_W(DATA_W)) u_txbuf (
    .clk      (clk),
    .rst      (rst),
    .accept   (host_accept),
    .wdata    (host_wdata),
    .load     (ev_tx_load),
    .flush    (flush),
    .tx_byte  (tx_byte),
    .tx_valid (tx_valid)
  );

  qc_status_regs u_status (
    .clk          (clk),
    .rst          (rst),
    .matched      (matched),
    .match_rd     (match_rd),
    .next_req     (next_req),
    .host_accept  (host_accept),
    .flush        (flush),
    .end_stop     (end_stop),
    .end_quick    (end_quick),
    .dir          (dir),
    .stop_ack     (stop_ack),
    .data_req_irq (data_req_irq),
    .scl_hold     (scl_hold),
    .stop_irq     (stop_irq),
    .qcmd_flag    (qcmd_flag),
    .qcmd_dir     (qcmd_dir)
  );
endmodule

// File: rtl/qc_slave_handler_chk.sv
module qc_slave_handler_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              ev_addr_match,
  input logic              ev_rw,
  input logic              host_wr,
  input logic              ev_tx_load,
  input logic              stop_ack,
  input logic              data_req_irq,
  input logic              stop_irq,
  input logic              qcmd_flag,
  input logic [DATA_W-1:0] tx_byte,
  input logic              tx_valid
);
  // R3
  rd_match_requests_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_addr_match && ev_rw && !ev_start && !ev_stop) |=> data_req_irq);

  // R2
  wr_match_no_request_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_addr_match && !ev_rw && !ev_start && !ev_stop) |=> !data_req_irq);

  // R8
  unrequested_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !data_req_irq) |=> $stable(tx_byte));

  // R2
  qcmd_only_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(qcmd_flag) |-> $past(ev_stop));

  // R7
  restart_no_qcmd_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_start && !ev_stop) |=> !$rose(qcmd_flag) && !$rose(stop_irq));

  // R10
  stop_ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_ack && !ev_stop) |=> !stop_irq);

  // R11
  load_consumes_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_tx_load && !host_wr) |=> !tx_valid);
endmodule

bind qc_slave_handler qc_slave_handler_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ev_start      (ev_start),
  .ev_stop       (ev_stop),
  .ev_addr_match (ev_addr_match),
  .ev_rw         (ev_rw),
  .host_wr       (host_wr),
  .ev_tx_load    (ev_tx_load),
  .stop_ack      (stop_ack),
  .data_req_irq  (data_req_irq),
  .stop_irq      (stop_irq),
  .qcmd_flag     (qcmd_flag),
  .tx_byte       (tx_byte),
  .tx_valid      (tx_valid)
);

// File: tb/sim_qc_slave_handler.sv
module sim_qc_slave_handler;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_start = 0, ev_stop = 0, ev_addr_match = 0, ev_rw = 0, ev_bit = 0;
  logic ev_tx_next = 0, ev_tx_load = 0, host_wr = 0, stop_ack = 0;
  logic [DW-1:0] host_wdata = '0;
  logic data_req_irq, stop_irq, qcmd_flag, qcmd_dir, scl_hold, tx_valid;
  logic [DW-1:0] tx_byte;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qc_slave_handler #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_addr_match(ev_addr_match), .ev_rw(ev_rw), .ev_bit(ev_bit),
    .ev_tx_next(ev_tx_next), .ev_tx_load(ev_tx_load), .host_wr(host_wr),
    .host_wdata(host_wdata), .stop_ack(stop_ack),
    .data_req_irq(data_req_irq), .stop_irq(stop_irq), .qcmd_flag(qcmd_flag),
    .qcmd_dir(qcmd_dir), .scl_hold(scl_hold), .tx_byte(tx_byte),
    .tx_valid(tx_valid)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Event pulses: raised at a falling edge, dropped at the next one,
  // so outputs are settled when the task returns.
  task automatic p_start();
    @(negedge clk) ev_start = 1; @(negedge clk) ev_start = 0;
  endtask
  task automatic p_stop();
    @(negedge clk) ev_stop = 1; @(negedge clk) ev_stop = 0;
  endtask
  task automatic p_addr(input logic rw);
    @(negedge clk) begin ev_addr_match = 1; ev_rw = rw; end
    @(negedge clk) ev_addr_match = 0;
  endtask
  task automatic p_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ev_bit = 1; @(negedge clk) ev_bit = 0;
    end
  endtask
  task automatic p_write(input logic [DW-1:0] d);
    @(negedge clk) begin host_wr = 1; host_wdata = d; end
    @(negedge clk) host_wr = 0;
  endtask
  task automatic p_load();
    @(negedge clk) ev_tx_load = 1; @(negedge clk) ev_tx_load = 0;
  endtask
  task automatic p_next();
    @(negedge clk) ev_tx_next = 1; @(negedge clk) ev_tx_next = 0;
  endtask
  task automatic p_ack();
    @(negedge clk) stop_ack = 1; @(negedge clk) stop_ack = 0;
  endtask

  task automatic t_reset();
    check("R1", "data_req_irq", data_req_irq, 0);
    check("R1", "stop_irq", stop_irq, 0);
    check("R1", "qcmd_flag", qcmd_flag, 0);
    check("R1", "qcmd_dir", qcmd_dir, 0);
    check("R1", "scl_hold", scl_hold, 0);
    check("R1", "tx_valid", tx_valid, 0);
    check("R1", "tx_byte", tx_byte, 0);
  endtask

  task automatic t_quick_write();
    p_start(); p_addr(1'b0);
    check("R2", "data_req_irq after write match", data_req_irq, 0);
    check("R2", "scl_hold after write match", scl_hold, 0);
    p_stop();
    check("R2", "qcmd_flag", qcmd_flag, 1);
    check("R2", "qcmd_dir", qcmd_dir, 0);
    check("R2", "stop_irq", stop_irq, 1);
    p_ack();
    check("R10", "stop_irq after ack", stop_irq, 0);
    check("R10", "qcmd_flag after ack", qcmd_flag, 1);
  endtask

  task automatic t_quick_read();
    p_start();
    check("R6", "qcmd_flag after bare START", qcmd_flag, 1);
    p_addr(1'b1);
    check("R6", "qcmd_flag cleared by match", qcmd_flag, 0);
    check("R3", "data_req_irq", data_req_irq, 1);
    check("R3", "scl_hold", scl_hold, 1);
    p_write(8'hFF);
    check("R4", "tx_byte", tx_byte, 8'hFF);
    check("R4", "tx_valid", tx_valid, 1);
    check("R4", "data_req_irq after write", data_req_irq, 0);
    check("R4", "scl_hold after write", scl_hold, 0);
    p_load();
    check("R11", "tx_valid after load", tx_valid, 0);
    p_stop();
    check("R4", "qcmd_flag", qcmd_flag, 1);
    check("R4", "qcmd_dir", qcmd_dir, 1);
    check("R4", "stop_irq", stop_irq, 1);
    p_ack();
  endtask

  task automatic t_ignored_write();
    p_write(8'h55);
    check("R8", "tx_byte idle write", tx_byte, 8'hFF);
    check("R8", "tx_valid idle write", tx_valid, 0);
    p_start(); p_addr(1'b0);
    p_write(8'h12);
    check("R8", "tx_byte write-dir write", tx_byte, 8'hFF);
    check("R8", "tx_valid write-dir write", tx_valid, 0);
    p_stop(); p_ack();
  endtask

  task automatic t_normal_write();
    p_start(); p_addr(1'b0); p_bits(8); p_stop();
    check("R5", "stop_irq", stop_irq, 1);
    check("R5", "qcmd_flag", qcmd_flag, 0);
    p_ack();
  endtask

  task automatic t_read_next();
    p_start(); p_addr(1'b1); p_write(8'hA5); p_load(); p_bits(8);
    check("R11", "data_req_irq before next", data_req_irq, 0);
    p_next();
    check("R11", "data_req_irq after next", data_req_irq, 1);
    p_write(8'h3C);
    check("R11", "tx_byte second", tx_byte, 8'h3C);
    p_stop();
    check("R5", "qcmd_flag multi-byte read", qcmd_flag, 0);
    check("R5", "stop_irq multi-byte read", stop_irq, 1);
    p_ack();
  endtask

  task automatic t_restart();
    p_start(); p_addr(1'b1); p_write(8'h80);
    p_start();
    check("R7", "qcmd_flag", qcmd_flag, 0);
    check("R7", "stop_irq", stop_irq, 0);
    check("R7", "tx_valid", tx_valid, 0);
    p_addr(1'b1);
    p_start();
    check("R7", "data_req_irq", data_req_irq, 0);
  endtask

  task automatic t_unmatched_stop();
    p_start(); p_addr(1'b0); p_stop(); p_ack();
    p_start(); p_stop();
    check("R9", "stop_irq", stop_irq, 0);
    check("R9", "qcmd_flag", qcmd_flag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_quick_write();
    t_quick_read();
    t_ignored_write();
    t_normal_write();
    t_read_next();
    t_restart();
    t_unmatched_stop();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule